// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block forms the full double-width product of two unsigned W-bit integers. It uses one W-bit adder over W clock cycles instead of a full array multiplier. A one-cycle start strobe captures both operands. The block then retires one multiplier bit per clock. On each step it adds the multiplicand into an accumulator when the current low multiplier bit is set. It then shifts the carry, the accumulator and the multiplier register right together by one position.

The upper half of the result collects in the accumulator. The lower half fills the multiplier register as the multiplier bits are consumed. When the last bit is done, a one-cycle completion pulse marks the product as valid. The product stays on the output until the next accepted start. The width W is a parameter and defaults to 8.

Top module: `shiftadd_mul`

## Requirements
- R1: While reset is asserted and immediately after it, `busy_o` and `done_o` are 0 and `product_o` is 0.
- R2: When `done_o` is 1, `product_o` equals the unsigned product of the multiplicand and multiplier captured at the accepted start, as a 2W-bit value.
- R3: A start is accepted on a rising clock edge where `start_i` is 1 and `busy_o` is 0. `busy_o` is then 1 for exactly W cycles, and `done_o` is 1 in the cycle that follows those W busy cycles.
- R4: `done_o` is 1 for a single cycle per operation. If no new start is accepted, the block returns to idle with `done_o` at 0.
- R5: A `start_i` pulse while `busy_o` is 1 is ignored. It neither changes the result nor lengthens or restarts the operation.
- R6: `product_o` holds its value on every cycle after completion until a new start is accepted.
- R7: Changes on `mcand_i` or `mplier_i` after the start edge do not affect the result of the running operation.
- R8: A zero operand yields a zero product. All-ones operands yield (2^W-1)^2.
- R9: `busy_o` and `done_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted when not busy |
| mcand_i | input | W | Multiplicand, sampled at the accepted start |
| mplier_i | input | W | Multiplier, sampled at the accepted start |
| busy_o | output | 1 | High while shift-add steps are running |
| done_o | output | 1 | One-cycle pulse when the product is valid |
| product_o | output | 2W | Product, upper half from accumulator, lower half from multiplier register |

## Verification
Take the start edge as edge 0. Operands load at that edge, and `busy_o` reads 1 in the half cycle that follows. The W steps complete on edges 1 through W. `done_o` and the final product are therefore due after edge W, and `done_o` falls after edge W+1. The bench drives inputs on falling edges and counts exactly that many falling edges before it samples busy, done and the product. It checks the cycle after the pulse for the falling done and the held product. For the ignored-start and operand-change cases it uses the same fixed sample points, so any extra or restarted step moves the pulse and is caught.

// File: rtl/shiftadd_mul_pkg.sv
package shiftadd_mul_pkg;

    typedef enum logic [1:0] {
        MS_IDLE = 2'd0,
        MS_RUN  = 2'd1,
        MS_DONE = 2'd2
    } mul_state_e;

endpackage

// File: rtl/shiftadd_mul_ctrl.sv
module shiftadd_mul_ctrl
    import shiftadd_mul_pkg::*;
#(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);
    localparam int          CW   = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        mul_state_e      st;
        logic [CW-1:0]   cnt;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  load_d;

    always_comb begin
        c_d    = c_q;
        load_d = 1'b0;
        unique case (c_q.st)
            MS_RUN: begin
                c_d.cnt = c_q.cnt + 1'b1;
                if (c_q.cnt == LAST) begin
                    c_d.st = MS_DONE;
                end
            end
            MS_DONE: begin
                if (start_i) begin
                    c_d.st  = MS_RUN;
                    c_d.cnt = '0;
                    load_d  = 1'b1;
                end else begin
                    c_d.st = MS_IDLE;
                end
            end
            default: begin
                if (start_i) begin
                    c_d.st  = MS_RUN;
                    c_d.cnt = '0;
                    load_d  = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st  <= MS_IDLE;
            c_q.cnt <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign load_o = load_d;
    assign step_o = (c_q.st == MS_RUN);
    assign busy_o = (c_q.st == MS_RUN);
    assign done_o = (c_q.st == MS_DONE);

endmodule

// File: rtl/shiftadd_mul_adder.sv
module shiftadd_mul_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] s_o,
    output logic         c_o
);
    logic [W:0] cy;

    assign cy[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign s_o[i]  = x_i[i] ^ y_i[i] ^ cy[i];
        assign cy[i+1] = (x_i[i] & y_i[i]) | (cy[i] & (x_i[i] ^ y_i[i]));
    end

    assign c_o = cy[W];

endmodule

// File: rtl/shiftadd_mul_datapath.sv
module shiftadd_mul_datapath #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic           step_i,
    input  logic [W-1:0]   mcand_i,
    input  logic [W-1:0]   mplier_i,
    output logic [2*W-1:0] product_o
);
    typedef struct packed {
        logic [W-1:0] m;
        logic [W-1:0] a;
        logic [W-1:0] q;
    } dp_t;

    dp_t          r_d, r_q;
    logic [W-1:0] addend;
    logic [W-1:0] sum;
    logic         carry;

    // the multiplicand is gated to zero when the current multiplier bit is clear
    assign addend = r_q.q[0] ? r_q.m : '0;

    shiftadd_mul_adder #(.W(W)) u_add (
        .x_i (r_q.a),
        .y_i (addend),
        .s_o (sum),
        .c_o (carry)
    );

    always_comb begin
        r_d = r_q;
        if (load_i) begin
            r_d.m = mcand_i;
            r_d.a = '0;
            r_d.q = mplier_i;
        end else if (step_i) begin
            // carry:sum:q moves right one place, old q[0] falls off
            r_d.a = {carry, sum[W-1:1]};
            r_d.q = {sum[0], r_q.q[W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign product_o = {r_q.a, r_q.q};

endmodule

// File: rtl/shiftadd_mul.sv
module shiftadd_mul #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [W-1:0]   mcand_i,
    input  logic [W-1:0]   mplier_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [2*W-1:0] product_o
);
    logic load;
    logic step;

    shiftadd_mul_ctrl #(.W(W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    shiftadd_mul_datapath #(.W(W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .step_i    (step),
        .mcand_i   (mcand_i),
        .mplier_i  (mplier_i),
        .product_o (product_o)
    );

endmodule

// File: rtl/shiftadd_mul_chk.sv
module shiftadd_mul_chk #(
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start_i,
    input logic [W-1:0]   mcand_i,
    input logic [W-1:0]   mplier_i,
    input logic           busy_o,
    input logic           done_o,
    input logic [2*W-1:0] product_o
);
    localparam int CW = $clog2(W + 2);

    logic [2*W-1:0] want_q;
    logic [CW-1:0]  run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            want_q <= '0;
            run_q  <= '0;
        end else begin
            if (start_i && !busy_o) begin
                want_q <= (2*W)'(mcand_i) * (2*W)'(mplier_i);
            end
            run_q <= busy_o ? run_q + 1'b1 : '0;
        end
    end

    AST_RESULT_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (product_o == want_q)); // R2

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (run_q == CW'(W))); // R3

    AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(busy_o)); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R4

    AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !busy_o) |=> $stable(product_o)); // R6

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o)); // R9

endmodule

bind shiftadd_mul shiftadd_mul_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .product_o (product_o)
);

// File: tb/shiftadd_mul_test.sv
`timescale 1ns/1ps
module shiftadd_mul_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit over   = 1'b0;

    // width-4 instance
    logic       s4 = 1'b0;
    logic [3:0] a4 = '0, b4 = '0;
    logic       busy4, done4;
    logic [7:0] p4;

    // width-8 instance
    logic        s8 = 1'b0;
    logic [7:0]  a8 = '0, b8 = '0;
    logic        busy8, done8;
    logic [15:0] p8;

    shiftadd_mul #(.W(4)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(s4), .mcand_i(a4), .mplier_i(b4),
        .busy_o(busy4), .done_o(done4), .product_o(p4));

    shiftadd_mul #(.W(8)) uut_w8 (
        .clk(clk), .rst_n(rst_n), .start_i(s8), .mcand_i(a8), .mplier_i(b8),
        .busy_o(busy8), .done_o(done8), .product_o(p8));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!over) begin
            over = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // one full operation on the width-4 unit
    task automatic op4(input logic [3:0] a, input logic [3:0] b);
        logic [7:0] exp = 8'(a) * 8'(b);
        @(negedge clk); a4 = a; b4 = b; s4 = 1'b1;
        @(negedge clk); s4 = 1'b0;
        check("R3 busy4 after start", {31'd0, busy4}, 32'd1);
        repeat (4) @(negedge clk);
        check("R3 done4 due", {30'd0, busy4, done4}, 32'd1);
        check("R2 product4", {24'd0, p4}, {24'd0, exp});
        @(negedge clk);
        check("R4 done4 falls", {31'd0, done4}, 32'd0);
        check("R6 product4 held", {24'd0, p4}, {24'd0, exp});
    endtask

    // width-8 operation; disturb selects a mid-run start pulse and operand change
    task automatic op8(input logic [7:0] a, input logic [7:0] b, input bit disturb);
        logic [15:0] exp = 16'(a) * 16'(b);
        @(negedge clk); a8 = a; b8 = b; s8 = 1'b1;
        @(negedge clk); s8 = 1'b0;
        if (disturb) begin
            repeat (2) @(negedge clk);
            a8 = ~a; b8 = b + 8'd3; s8 = 1'b1;   // R5 start while busy, R7 new operands
            @(negedge clk); s8 = 1'b0;
            repeat (5) @(negedge clk);
        end else begin
            repeat (8) @(negedge clk);
        end
        check("R3 done8 due", {30'd0, busy8, done8}, 32'd1);
        check(disturb ? "R5 R7 product8 undisturbed" : "R2 product8",
              {16'd0, p8}, {16'd0, exp});
        @(negedge clk);
        check("R4 done8 falls", {30'd0, busy8, done8}, 32'd0);
    endtask

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog actual %0d expected <150000 cycles", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset busy/done", {28'd0, busy4, done4, busy8, done8}, 32'd0);
        check("R1 reset product", {8'd0, p4, p8}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {12'd0, busy4, done4, busy8, done8, p8}, 32'd0);

        // exhaustive width 4, includes zero and all-ones (R8)
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
                op4(4'(i), 4'(j));

        // width 8 corners, R8
        op8(8'd0, 8'd0, 1'b0);
        op8(8'd0, 8'hFF, 1'b0);
        op8(8'hFF, 8'd0, 1'b0);
        op8(8'hFF, 8'hFF, 1'b0);
        check("R8 all-ones product8", {16'd0, p8}, 32'd65025);
        op8(8'd1, 8'hA5, 1'b0);
        op8(8'h80, 8'h80, 1'b0);

        // R5 and R7: disturbance during the run
        op8(8'd37, 8'd201, 1'b1);
        op8(8'hFF, 8'hFF, 1'b1);

        // R6: product holds through idle cycles with changing inputs
        a8 = 8'h12; b8 = 8'h34;
        repeat (5) @(negedge clk);
        check("R6 idle hold product8", {16'd0, p8}, 32'd65025);
        check("R4 R9 idle flags", {30'd0, busy8, done8}, 32'd0);

        // random width 8
        for (int k = 0; k < 300; k++)
            op8(8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)), 1'b0);

        finish_run();
    end

endmodule